// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block runs the start-up routine that a memory device without a reset pin needs before it will accept traffic. Once the clock runs and the power-good input reports stable supplies, the sequencer holds off for a programmed settling pause. It then places three consecutive mode-register commands on the command strobe. The first two are throw-away cycles, and a qualifier marks the third as the one carrying the real setting. After a minimum gap it issues one refresh to every bank in ascending bank order, with a fixed spacing between refreshes. A final settle interval then raises a sticky ready flag.

The pause length is given in microseconds and converted to clock cycles from a clock-frequency parameter, rounding up. The other intervals are parameters given directly in cycles. The strobes are plain one-cycle command pulses with no handshake. The memory controller that owns the command bus simply forwards them and waits for `init_done` before it starts normal traffic. A synchronous reset abandons any sequence in progress and starts over.

Top module: `init_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low in the following cycle. Once `rst` is released the sequence restarts from the idle state and waits for power-good again.
- R2: While `pwr_good` stays low after reset, the block issues no strobe and `init_done` stays low.
- R3: The first `cmd_mrs` cycle comes exactly PAUSE_CYC cycles after the first clock edge that sees `pwr_good` high with `rst` low. PAUSE_CYC = ceil(CLK_HZ * PAUSE_US / 1e6), which is 20000 at the defaults. No strobe is issued before that cycle.
- R4: `cmd_mrs` is high for exactly N_DUMMY+1 consecutive cycles (3 at the defaults). `mrs_valid` is high only in the last of them.
- R5: The first `cmd_ref` comes exactly T_MRSC cycles after the last `cmd_mrs` cycle (12 at the defaults).
- R6: Exactly NUM_BANKS refresh pulses are issued, each one cycle wide and spaced REF_GAP cycles apart (8 and 2048 at the defaults). `bank_idx` reads 0, 1, …, NUM_BANKS-1 on successive pulses and is 0 whenever `cmd_ref` is low.
- R7: `init_done` rises exactly T_RC cycles after the last refresh pulse (10 at the defaults) and stays high until reset.
- R8: `cmd_mrs` and `cmd_ref` are never high in the same cycle. Both stay low during the pause, the waits and after `init_done`.
- R9: Once the pause has started, later changes of `pwr_good` do not change the timing or content of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, already running before the sequence starts |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| pwr_good | input | 1 | High once supplies are stable; sampled only while idle |
| cmd_mrs | output | 1 | Mode-register-set command strobe |
| mrs_valid | output | 1 | Marks the mode-register cycle that carries the real setting |
| cmd_ref | output | 1 | Refresh command strobe |
| bank_idx | output | BANK_W | Target bank of the current refresh, 0 otherwise |
| init_done | output | 1 | Sticky ready flag |

## Verification
All timing is counted from the first edge that sees power-good with reset low. The mode-register pulses fall due PAUSE_CYC, +1 and +2 cycles after that edge. The first refresh follows T_MRSC cycles after the last of them, each further refresh another REF_GAP cycles later, and ready T_RC cycles after the final refresh. The bench counts rising edges and drives its inputs on the falling edge. It compares a table of expected output vectors at those exact cycle offsets, and also at the cycle just before each event, where the outputs must still be quiet. A falling-edge monitor counts every strobe cycle over the whole run. This catches stray or overlapping pulses between the sampled points. Reset is checked one cycle after it is applied, both mid-sequence and after ready.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_MRS,
    ST_MRSC,
    ST_REF,
    ST_GAP,
    ST_RC,
    ST_DONE
  } init_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/init_delay_timer.sv
module init_delay_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

  // a loaded nonzero count must not read as expired on the next cycle
  AST_TIMER_LOADED: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired); // R5

endmodule

// File: rtl/init_step_counter.sv
module init_step_counter #(
  parameter int unsigned W    = 3,
  parameter int unsigned LAST = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         at_last
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value <= '0;
    end else if (step) begin
      value <= value + W'(1);
    end
  end

  assign at_last = (value == W'(LAST));

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !at_last) |=> value == W'($past(value) + W'(1))); // R6

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer
  import init_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned PAUSE_US  = 200,
  parameter int unsigned N_DUMMY   = 2,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned REF_GAP   = 2048,
  parameter int unsigned T_MRSC    = 12,
  parameter int unsigned T_RC      = 10,
  localparam int unsigned BANK_W   = bits_for(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  output logic              cmd_mrs,
  output logic              mrs_valid,
  output logic              cmd_ref,
  output logic [BANK_W-1:0] bank_idx,
  output logic              init_done
);

  // pause converted to cycles, rounded up; valid ranges: pause >= 1 cycle,
  // N_DUMMY >= 1, REF_GAP/T_MRSC/T_RC >= 2
  localparam longint unsigned PAUSE_PROD = longint'(CLK_HZ) * longint'(PAUSE_US);
  localparam int unsigned PAUSE_CYC = int'((PAUSE_PROD + 64'd999_999) / 64'd1_000_000);
  localparam int unsigned MRS_TOTAL = N_DUMMY + 1;
  localparam int unsigned MRS_W     = bits_for(MRS_TOTAL);
  localparam int unsigned MAX_WAIT  = max_u(max_u(PAUSE_CYC, REF_GAP), max_u(T_MRSC, T_RC));
  localparam int unsigned CNT_W     = $clog2(MAX_WAIT + 1);

  init_state_e state_q, state_d;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  logic             mrs_step, bank_step, seq_clr;
  logic [MRS_W-1:0]  mrs_cnt;
  logic              mrs_last;
  logic [BANK_W-1:0] bank_cnt;
  logic              bank_last;

  init_delay_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  init_step_counter #(.W(MRS_W), .LAST(N_DUMMY)) u_mrs_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (seq_clr),
    .step   (mrs_step),
    .value  (mrs_cnt),
    .at_last(mrs_last)
  );

  init_step_counter #(.W(BANK_W), .LAST(NUM_BANKS - 1)) u_bank_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (seq_clr),
    .step   (bank_step),
    .value  (bank_cnt),
    .at_last(bank_last)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    mrs_step  = 1'b0;
    bank_step = 1'b0;
    seq_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        seq_clr = 1'b1;
        if (pwr_good) begin
          state_d  = ST_PAUSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PAUSE_CYC - 1);
        end
      end
      ST_PAUSE: begin
        if (tmr_expired) state_d = ST_MRS;
      end
      ST_MRS: begin
        mrs_step = 1'b1;
        if (mrs_last) begin
          state_d  = ST_MRSC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_MRSC - 2);
        end
      end
      ST_MRSC: begin
        if (tmr_expired) state_d = ST_REF;
      end
      ST_REF: begin
        tmr_load = 1'b1;
        if (bank_last) begin
          state_d = ST_RC;
          tmr_val = CNT_W'(T_RC - 2);
        end else begin
          state_d   = ST_GAP;
          tmr_val   = CNT_W'(REF_GAP - 2);
          bank_step = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_expired) state_d = ST_REF;
      end
      ST_RC: begin
        if (tmr_expired) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign cmd_mrs   = (state_q == ST_MRS);
  assign mrs_valid = (state_q == ST_MRS) && mrs_last;
  assign cmd_ref   = (state_q == ST_REF);
  assign bank_idx  = (state_q == ST_REF) ? bank_cnt : '0;
  assign init_done = (state_q == ST_DONE);

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!init_done && !cmd_mrs && !cmd_ref)); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(cmd_mrs && cmd_ref)); // R8
  AST_VALID_QUAL: assert property (@(posedge clk) disable iff (rst)
    mrs_valid |-> (cmd_mrs && $past(cmd_mrs))); // R4
  AST_VALID_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    mrs_valid |=> !cmd_mrs); // R4
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_ref |=> !cmd_ref); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (!cmd_mrs && !cmd_ref)); // R8

endmodule

// File: tb/tb_init_sequencer.sv
module tb_init_sequencer;

  localparam int P    = 20000;
  localparam int TM   = 12;
  localparam int GAP  = 2048;
  localparam int TRC  = 10;
  localparam int R0   = P + 2 + TM;
  localparam int RL   = R0 + 7 * GAP;
  localparam int NROW = 17;

  // expected vectors: cycle offset from start edge, {mrs, valid, ref, done}, bank
  localparam int EV_T [NROW] = '{
    P - 1, P, P + 1, P + 2, P + 3, R0 - 1, R0, R0 + GAP - 1,
    R0 + GAP, R0 + 2*GAP, R0 + 3*GAP, R0 + 4*GAP, R0 + 5*GAP, R0 + 6*GAP, RL,
    RL + TRC - 1, RL + TRC};
  localparam logic [3:0] EV_EXP [NROW] = '{
    4'b0000, 4'b1000, 4'b1000, 4'b1100, 4'b0000, 4'b0000, 4'b0010, 4'b0000,
    4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010,
    4'b0000, 4'b0001};
  localparam int EV_BANK [NROW] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 3, 4, 5, 6, 7, 0, 0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good = 1'b0;
  logic       cmd_mrs, mrs_valid, cmd_ref, init_done;
  logic [2:0] bank_idx;

  int cyc = 0;
  int e0 = 0;
  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  int n_mrs = 0, n_ref = 0, n_both = 0, n_badbank = 0;

  init_sequencer dut (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .cmd_mrs  (cmd_mrs),
    .mrs_valid(mrs_valid),
    .cmd_ref  (cmd_ref),
    .bank_idx (bank_idx),
    .init_done(init_done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (cmd_mrs) n_mrs++;
      if (cmd_ref) n_ref++;
      if (cmd_mrs && cmd_ref) n_both++;
      if (!cmd_ref && bank_idx != 3'd0) n_badbank++;
    end
  end

  function automatic string row_req(input int i);
    if (i <= 1) return "R3";
    if (i <= 3) return "R4";
    if (i == 4 || i == 7) return "R8";
    if (i <= 6) return "R5";
    if (i <= 14) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp_v);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < e0 + t) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {cmd_mrs, mrs_valid, cmd_ref, init_done};
  endfunction

  task automatic clear_mon();
    n_mrs = 0; n_ref = 0; n_both = 0; n_badbank = 0;
  endtask

  task automatic run_table();
    for (int i = 0; i < NROW; i++) begin
      wait_to(EV_T[i]);
      check(outs() == EV_EXP[i] && int'(bank_idx) == EV_BANK[i], row_req(i),
            {outs(), 1'b0, bank_idx}, {EV_EXP[i], 1'b0, 3'(EV_BANK[i])});
    end
  endtask

  task automatic check_counts();
    check(n_mrs == 3, "R4", n_mrs, 3);
    check(n_ref == 8, "R6", n_ref, 8);
    check(n_both == 0, "R8", n_both, 0);
    check(n_badbank == 0, "R6", n_badbank, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: outputs held low under reset
    repeat (3) @(negedge clk);
    check({outs(), bank_idx} == 7'd0, "R1", {outs(), bank_idx}, 0);

    // R2: no progress without power-good
    rst = 1'b0;
    repeat (40) @(negedge clk);
    check({outs(), bank_idx} == 7'd0, "R2", {outs(), bank_idx}, 0);

    // first full sequence
    pwr_good = 1'b1;
    e0 = cyc + 1;
    clear_mon();
    mon_en = 1'b1;
    run_table();
    check_counts();
    wait_to(RL + TRC + 200);
    check(outs() == 4'b0001, "R7", outs(), 4'b0001);
    mon_en = 1'b0;

    // R1: reset after ready drops the flag next cycle
    rst = 1'b1;
    @(negedge clk);
    check(init_done == 1'b0, "R1", init_done, 0);

    // restart with power-good already high, then reset mid refresh gap
    rst = 1'b0;
    e0 = cyc + 1;
    wait_to(R0 + 3 * GAP + 5);
    rst = 1'b1;
    @(negedge clk);
    check({outs(), bank_idx} == 7'd0, "R1", {outs(), bank_idx}, 0);

    // R1 restart from pause; R9 power-good drop during pause ignored
    rst = 1'b0;
    e0 = cyc + 1;
    clear_mon();
    mon_en = 1'b1;
    wait_to(P / 2);
    pwr_good = 1'b0;
    run_table();
    check_counts();
    wait_to(RL + TRC + 50);
    check(outs() == 4'b0001, "R9", outs(), 4'b0001);
    mon_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule